// File: doc/BRIEF.md
# Stacked Interrupt Status Controller

This block collects single-cycle condition pulses from a bus-side protocol core and a DMA/script engine. It records them in a visible status register and decides whether each one must stop the script engine and interrupt the host. Every source bit has a fixed class: some bits are always fatal. The rest are nonfatal, and a nonfatal bit becomes fatal when software sets its enable bit. A fatal bit that appears in status drives the active-low interrupt request and gives the engine a one-cycle halt pulse.

Status is cleared by reading it. Conditions that arrive while status is still pending, or in the same cycle as the clearing read, do not enter the visible register. They wait in a one-deep stack for each bit and move into status on the clock after the clear. After a clearing read, the request pin is held inactive for a programmable minimum gap. This lets the host see a distinct edge for the stacked interrupt.

Top module: `irq_stack_ctrl`

## Requirements
- R1: The visible status records every condition that occurs, whether or not its enable bit is set. Bit i of `status_o` corresponds to bit i of `cond_i`.
- R2: A bit whose position is set in parameter FATAL_MASK (default 0x0F) drives `irq_n_o` low and pulses `halt_o` when it becomes visible, whatever its enable bit.
- R3: A nonfatal bit whose `enable_i` bit is set behaves as fatal: `irq_n_o` goes low and `halt_o` pulses.
- R4: A nonfatal bit whose enable is clear sets its status bit but leaves `irq_n_o` high and `halt_o` low.
- R5: A read strobe returns the current visible contents on `status_o` in the strobe cycle and clears them at the same edge.
- R6: A condition that arrives while visible status is nonzero, or during a read cycle, is held back. Visible status does not change until a read. Held bits appear in status one clock after the clearing edge.
- R7: The stack holds one level for each bit. Repeated occurrences of a held bit merge into a single set bit.
- R8: After a read that clears nonzero status, `irq_n_o` stays high for at least GAP_CYCLES clocks (default 3), even if fatal bits are visible. After that it reflects the fatal status again.
- R9: `halt_o` is high for exactly one cycle, in the first cycle that a fatal bit is visible.
- R10: While reset is asserted and just after it, status is zero, `irq_n_o` is high and `halt_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | N_SRC | Raw condition pulses, one per source |
| enable_i | input | N_SRC | Per-bit enables that promote nonfatal bits to fatal |
| rd_i | input | 1 | Status read strobe (read-to-clear) |
| status_o | output | N_SRC | Visible status contents |
| irq_n_o | output | 1 | Active-low interrupt request |
| halt_o | output | 1 | One-cycle halt request to the script engine |

## Verification
The bench first builds up a stack behind a pending fatal bit. It pulses one held bit twice and adds a masked bit, then reads. A design that leaked held bits into status early would show them before the read. A design that did not merge repeats would not return the single OR-combined word. The bench then follows the request pin cycle by cycle after the clearing read. A short or missing gap shows as an early low on `irq_n_o`, and a lost drain shows as an empty status. A condition that arrives in the read cycle itself must be held, not dropped or folded into the word being read. A masked nonfatal bit must never pull the pin low or pulse the halt.

// File: rtl/isc_pkg.sv
package isc_pkg;
   typedef enum logic [1:0] {
      RT_HOLD  = 2'd0,
      RT_LOAD  = 2'd1,
      RT_DRAIN = 2'd2,
      RT_CLEAR = 2'd3
   } route_e;

   function automatic int cnt_bits(input int v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction
endpackage

// File: rtl/isc_bit_cell.sv
module isc_bit_cell
   import isc_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  route_e route,
   input  logic   cond,
   output logic   vis,
   output logic   stk
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vis <= 1'b0;
         stk <= 1'b0;
      end else begin
         case (route)
            RT_CLEAR: begin
               vis <= 1'b0;
               stk <= stk | cond;
            end
            RT_DRAIN: begin
               vis <= stk | cond;
               stk <= 1'b0;
            end
            RT_LOAD: begin
               vis <= cond;
            end
            default: begin
               stk <= stk | cond;
            end
         endcase
      end
   end
endmodule

// File: rtl/isc_gap_timer.sv
module isc_gap_timer #(
   parameter int GAP_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int W = isc_pkg::cnt_bits(GAP_CYCLES);
   localparam logic [W-1:0] LOAD_VAL = W'(GAP_CYCLES);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (start)
         cnt <= LOAD_VAL;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/isc_request.sv
module isc_request #(
   parameter int              N_SRC      = 8,
   parameter logic [N_SRC-1:0] FATAL_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] vis,
   input  logic [N_SRC-1:0] enable,
   input  logic             gap_busy,
   output logic             irq_n,
   output logic             halt
);
   logic [N_SRC-1:0] fatal_vis;
   logic [N_SRC-1:0] vis_prev;

   assign fatal_vis = vis & (FATAL_MASK | enable);

   always_ff @(posedge clk) begin
      if (!rst_n)
         vis_prev <= '0;
      else
         vis_prev <= vis;
   end

   assign irq_n = ~((|fatal_vis) & ~gap_busy);
   assign halt  = |(fatal_vis & ~vis_prev);
endmodule

// File: rtl/irq_stack_ctrl.sv
module irq_stack_ctrl
   import isc_pkg::*;
#(
   parameter int               N_SRC      = 8,
   parameter logic [N_SRC-1:0] FATAL_MASK = N_SRC'(8'h0F),
   parameter int               GAP_CYCLES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] cond_i,
   input  logic [N_SRC-1:0] enable_i,
   input  logic             rd_i,
   output logic [N_SRC-1:0] status_o,
   output logic             irq_n_o,
   output logic             halt_o
);
   if (N_SRC < 1) begin : g_bad_width
      $error("irq_stack_ctrl: N_SRC must be at least 1");
   end
   if (GAP_CYCLES < 3) begin : g_bad_gap
      $error("irq_stack_ctrl: GAP_CYCLES must be at least 3");
   end

   logic [N_SRC-1:0] vis;
   logic [N_SRC-1:0] stk;
   logic             vis_any;
   logic             stk_any;
   logic             gap_busy;
   route_e           route;

   assign vis_any = |vis;
   assign stk_any = |stk;

   always_comb begin
      if (rd_i)
         route = RT_CLEAR;
      else if (!vis_any && stk_any)
         route = RT_DRAIN;
      else if (!vis_any)
         route = RT_LOAD;
      else
         route = RT_HOLD;
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_cell
      isc_bit_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .route (route),
         .cond  (cond_i[i]),
         .vis   (vis[i]),
         .stk   (stk[i])
      );
   end

   isc_gap_timer #(
      .GAP_CYCLES (GAP_CYCLES)
   ) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .start (rd_i & vis_any),
      .busy  (gap_busy)
   );

   isc_request #(
      .N_SRC      (N_SRC),
      .FATAL_MASK (FATAL_MASK)
   ) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .vis      (vis),
      .enable   (enable_i),
      .gap_busy (gap_busy),
      .irq_n    (irq_n_o),
      .halt     (halt_o)
   );

   assign status_o = vis;
endmodule

// File: rtl/irq_stack_chk.sv
module irq_stack_chk #(
   parameter int               N_SRC      = 8,
   parameter logic [N_SRC-1:0] FATAL_MASK = '0,
   parameter int               GAP_CYCLES = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] cond_i,
   input logic [N_SRC-1:0] enable_i,
   input logic             rd_i,
   input logic [N_SRC-1:0] status_o,
   input logic             irq_n_o,
   input logic             halt_o
);
   int gap_left;

   always_ff @(posedge clk) begin
      if (!rst_n)
         gap_left <= 0;
      else if (rd_i && (status_o != '0))
         gap_left <= GAP_CYCLES;
      else if (gap_left > 0)
         gap_left <= gap_left - 1;
   end

   assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> (status_o == '0));

   assert_pending_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_i && (status_o != '0)) |=> (status_o == $past(status_o)));

   assert_irq_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_left != 0) |-> irq_n_o);

   assert_halt_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |=> !halt_o);

   assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_o & (FATAL_MASK | enable_i)) == '0) |-> (irq_n_o && !halt_o));
endmodule

bind irq_stack_ctrl irq_stack_chk #(
   .N_SRC      (N_SRC),
   .FATAL_MASK (FATAL_MASK),
   .GAP_CYCLES (GAP_CYCLES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cond_i   (cond_i),
   .enable_i (enable_i),
   .rd_i     (rd_i),
   .status_o (status_o),
   .irq_n_o  (irq_n_o),
   .halt_o   (halt_o)
);

// File: tb/irq_stack_ctrl_test.sv
`timescale 1ns/1ps
module irq_stack_ctrl_test;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] cond = '0;
   logic [N-1:0] en = '0;
   logic         rd = 1'b0;
   logic [N-1:0] status;
   logic         irq_n;
   logic         halt;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [N-1:0] exp_q[$];

   always #4 clk = ~clk;

   irq_stack_ctrl #(.N_SRC(N), .FATAL_MASK(8'h0F), .GAP_CYCLES(3)) uut (
      .clk(clk), .rst_n(rst_n), .cond_i(cond), .enable_i(en), .rd_i(rd),
      .status_o(status), .irq_n_o(irq_n), .halt_o(halt)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // monitor: read data compared against the scoreboard queue (R5)
   always @(negedge clk) begin
      #2;
      if (rd && rst_n) begin
         if (exp_q.size() == 0) begin
            check("R5 read without expectation", 1, 0);
         end else begin
            logic [N-1:0] e;
            e = exp_q.pop_front();
            check("R5 read data", int'(status), int'(e));
         end
      end
   end

   task automatic pulse(input logic [N-1:0] m);
      @(negedge clk); cond = m;
      @(negedge clk); cond = '0;
      #1;
   endtask

   task automatic do_read(input logic [N-1:0] exp, input logic [N-1:0] extra);
      @(negedge clk); rd = 1'b1; cond = extra; exp_q.push_back(exp);
      @(negedge clk); rd = 1'b0; cond = '0;
      #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R10 reset status", int'(status), 0);
      check("R10 reset irq_n", int'(irq_n), 1);
      check("R10 reset halt", int'(halt), 0);
      rst_n = 1'b1;
      idle(1);
      check("R10 after reset irq_n", int'(irq_n), 1);

      // masked nonfatal bit 4
      pulse(8'h10);
      check("R1 masked bit recorded", int'(status), 'h10);
      check("R4 masked irq_n", int'(irq_n), 1);
      check("R4 masked halt", int'(halt), 0);
      do_read(8'h10, '0);
      check("R5 cleared after read", int'(status), 0);
      idle(4);

      // fatal bit 0, no enable
      pulse(8'h01);
      check("R2 fatal irq_n", int'(irq_n), 0);
      check("R9 fatal halt pulse", int'(halt), 1);
      idle(1);
      check("R9 halt single cycle", int'(halt), 0);
      check("R2 irq held", int'(irq_n), 0);
      do_read(8'h01, '0);
      check("R8 irq released after read", int'(irq_n), 1);
      idle(4);

      // enabled nonfatal bit 5
      en = 8'h20;
      pulse(8'h20);
      check("R3 enabled irq_n", int'(irq_n), 0);
      check("R3 enabled halt", int'(halt), 1);
      do_read(8'h20, '0);
      idle(4);
      en = '0;

      // stack, merge and gap
      pulse(8'h01);
      pulse(8'h02);
      pulse(8'h02);
      pulse(8'h40);
      check("R6 pending status frozen", int'(status), 'h01);
      do_read(8'h01, '0);
      check("R6 status empty at clear", int'(status), 0);
      check("R8 gap cycle 1", int'(irq_n), 1);
      idle(1);
      check("R7 drained merged stack", int'(status), 'h42);
      check("R9 halt on drained fatal", int'(halt), 1);
      check("R8 gap cycle 2", int'(irq_n), 1);
      idle(1);
      check("R8 gap cycle 3", int'(irq_n), 1);
      check("R9 halt dropped", int'(halt), 0);
      idle(1);
      check("R8 irq after gap", int'(irq_n), 0);
      do_read(8'h42, '0);
      idle(4);

      // arrival during the read cycle
      pulse(8'h10);
      do_read(8'h10, 8'h08);
      check("R6 read-cycle arrival held", int'(status), 0);
      idle(1);
      check("R6 read-cycle arrival drained", int'(status), 'h08);
      check("R8 gap holds irq", int'(irq_n), 1);
      idle(3);
      check("R2 fatal irq after gap", int'(irq_n), 0);
      do_read(8'h08, '0);
      idle(4);

      // empty read
      do_read(8'h00, '0);
      check("R5 empty read keeps zero", int'(status), 0);
      check("R4 empty read irq_n", int'(irq_n), 1);
      idle(2);
      check("R5 scoreboard drained", exp_q.size(), 0);
      finish_run();
   end
endmodule